// File: doc/BRIEF.md
# Fast Ethernet PCS Transmit Encoder

This block turns the nibble stream of a media-independent transmit port into the serial line stream of a 100 Mb/s physical coding sublayer. It takes one 4-bit nibble and the transmit-enable flag per code-group slot. Each nibble becomes a 5-bit code group. The first two nibbles of every frame are sent as the start delimiter pair /J/ /K/. The end of the frame is marked with /T/ /R/, and idle code groups fill every slot outside a frame. The code groups are shifted out one bit per bit-clock enable, leftmost bit first, and the result is NRZI-encoded.

A slot lasts five bit enables. The block raises `nib_tick` in the cycle in which it samples `tx_en` and `txd`. The nibble source sets up its next nibble before that cycle and holds it until then. A collision flag is derived from the duplex setting, transmit enable and a receive-activity input, one clock after those inputs change.

Top module: `pcs_tx_encoder`

## Requirements
- R1: Each nibble is encoded as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. The leftmost bit goes onto the line first.
- R2: The slot in which `tx_en` is first sampled high while idle sends /J/ = 11000, and the next slot sends /K/ = 10001. The nibbles sampled in those two slots are not sent.
- R3: Every later nibble of the frame, including the remaining preamble nibbles, is sent with its R1 encoding and is not altered.
- R4: When `tx_en` is sampled low after the data, that slot sends /T/ = 01101 and the following slot sends /R/ = 00111.
- R5: Outside a frame, including the slot right after /R/, idle = 11111 is sent. A new code group starts every five bit enables with no gap, and `nib_tick` marks the sample cycle.
- R6: A frame whose `tx_en` is high for only one slot is still sent as /J/ /K/ /T/ /R/.
- R7: `tx_en` sampled high in the /R/ slot is ignored. The next frame's /J/ starts in the first following slot in which `tx_en` is high.
- R8: `tx_nrzi` toggles on a bit enable whose code bit is 1 and holds on one whose code bit is 0.
- R9: With `full_duplex` low, `col` is high one clock after `tx_en` and `rx_act` are both high, and low one clock after either is low.
- R10: With `full_duplex` high, `col` stays low whatever `tx_en` and `rx_act` do.
- R11: A synchronous active-low reset drives `tx_nrzi` and `col` low, and the first code group after reset is idle.
- R12: `tx_nrzi` does not change in a clock without a bit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One line bit per cycle in which this is high |
| tx_en | input | 1 | Transmit enable, sampled with `nib_tick` |
| txd | input | 4 | Transmit nibble, sampled with `nib_tick` |
| rx_act | input | 1 | Receive activity, used for collision |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| nib_tick | output | 1 | High in the cycle a nibble is taken |
| tx_nrzi | output | 1 | NRZI serial line output |
| col | output | 1 | Collision indication |

## Verification
The encoder is driven with long frames carrying a 5-valued preamble and then data that walks through all sixteen nibble values. These frames tell a wrong table entry or bit order apart from a wrong delimiter substitution. A one-nibble frame separates correct /J/ /K/ completion from an early jump to /T/. A frame whose enable rises during the /R/ slot checks that the trailing slot does not start a frame. The bit enable follows an irregular pattern, so stalls between bits expose any shifting or toggling without an enable. The collision checks cover all four combinations of transmit and receive activity in half duplex, and then activity under full duplex.

// File: rtl/pcs_tx_pkg.sv
// Shared types and code-group constants for the PCS transmit encoder.
package pcs_tx_pkg;
    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef logic [CG_W-1:0]  cg_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_K,
        FS_DATA,
        FS_T,
        FS_R
    } fstate_t;

    // Data nibble to 5-bit code group.
    function automatic cg_t enc_nibble(input nib_t n);
        case (n)
            4'h0: enc_nibble = 5'b11110;
            4'h1: enc_nibble = 5'b01001;
            4'h2: enc_nibble = 5'b10100;
            4'h3: enc_nibble = 5'b10101;
            4'h4: enc_nibble = 5'b01010;
            4'h5: enc_nibble = 5'b01011;
            4'h6: enc_nibble = 5'b01110;
            4'h7: enc_nibble = 5'b01111;
            4'h8: enc_nibble = 5'b10010;
            4'h9: enc_nibble = 5'b10011;
            4'hA: enc_nibble = 5'b10110;
            4'hB: enc_nibble = 5'b10111;
            4'hC: enc_nibble = 5'b11010;
            4'hD: enc_nibble = 5'b11011;
            4'hE: enc_nibble = 5'b11100;
            default: enc_nibble = 5'b11101;
        endcase
    endfunction
endpackage

// File: rtl/pcs_tx_framer.sv
// Frame sequencer: picks the code group for the next slot from the sampled
// enable and nibble. It substitutes /J/ /K/ for the first two nibbles,
// appends /T/ /R/ and fills idle.
// Assumes: load is high for one cycle per slot, and inputs are valid then.
module pcs_tx_framer
    import pcs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tx_en,
    input  nib_t txd,
    output cg_t  cg_next
);
    fstate_t st, st_nx;

    // Next code group and state for the slot being loaded.
    always_comb begin
        cg_next = CG_IDLE;
        st_nx   = st;
        case (st)
            FS_IDLE: begin
                if (tx_en) begin
                    cg_next = CG_J;
                    st_nx   = FS_K;
                end
            end
            FS_K: begin
                cg_next = CG_K;
                st_nx   = tx_en ? FS_DATA : FS_T;
            end
            FS_DATA: begin
                if (tx_en) begin
                    cg_next = enc_nibble(txd);
                end else begin
                    cg_next = CG_T;
                    st_nx   = FS_R;
                end
            end
            FS_T: begin
                cg_next = CG_T;
                st_nx   = FS_R;
            end
            FS_R: begin
                cg_next = CG_R;
                st_nx   = FS_IDLE;
            end
            default: begin
                cg_next = CG_IDLE;
                st_nx   = FS_IDLE;
            end
        endcase
    end

    // State advances only at slot boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)    st <= FS_IDLE;
        else if (load) st <= st_nx;
    end

    p_start_k_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st == FS_IDLE && tx_en) |=> (st == FS_K));
    p_k_then_data_or_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st == FS_K) |=> (st == FS_DATA || st == FS_T));
    p_r_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st == FS_R) |=> (st == FS_IDLE));
    p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st));
endmodule

// File: rtl/pcs_tx_serializer.sv
// Parallel-to-serial shifter: presents the code group MSB first, one bit per
// bit enable. It loads the next group on the enable that ends the current one.
// Assumes: cg_in is valid whenever load is high.
module pcs_tx_serializer
    import pcs_tx_pkg::*;
#(
    parameter int W = CG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic [W-1:0] cg_in,
    output logic         load,
    output logic         ser_bit
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     sreg;

    assign load    = bit_en && (cnt == LAST);
    assign ser_bit = sreg[W-1];

    // Bit position counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sreg <= W'(CG_IDLE);
        end else if (bit_en) begin
            if (load) begin
                cnt  <= '0;
                sreg <= cg_in;
            end else begin
                cnt  <= cnt + 1'b1;
                sreg <= {sreg[W-2:0], 1'b0};
            end
        end
    end

    p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sreg) && $stable(cnt)));
    p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0));
endmodule

// File: rtl/pcs_tx_nrzi.sv
// NRZI line coder: a 1 bit toggles the line on a bit enable, a 0 bit holds it.
// Assumes: ser_bit is the bit currently presented by the serializer.
module pcs_tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic ser_bit,
    output logic line
);
    // Line level register.
    always_ff @(posedge clk) begin
        if (!rst_n)      line <= 1'b0;
        else if (bit_en) line <= line ^ ser_bit;
    end

    p_toggle_on_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && ser_bit) |=> (line != $past(line)));
    p_hold_on_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !ser_bit) |=> $stable(line));
    p_hold_no_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line));
endmodule

// File: rtl/pcs_tx_col.sv
// Collision flag: registered AND of transmit and receive activity in half
// duplex, forced low in full duplex.
// Assumes: inputs are synchronous to clk.
module pcs_tx_col (
    input  logic clk,
    input  logic rst_n,
    input  logic full_duplex,
    input  logic tx_en,
    input  logic rx_act,
    output logic col
);
    // Collision register.
    always_ff @(posedge clk) begin
        if (!rst_n)           col <= 1'b0;
        else if (full_duplex) col <= 1'b0;
        else                  col <= tx_en & rx_act;
    end

    p_col_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !col);
    p_col_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && tx_en && rx_act) |=> col);
endmodule

// File: rtl/pcs_tx_encoder.sv
// Top of the PCS transmit encoder. It connects the frame sequencer, the
// serializer, the NRZI coder and the collision flag.
// Assumes: tx_en/txd are held stable around the cycle where nib_tick is high.
module pcs_tx_encoder
    import pcs_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       tx_en,
    input  logic [3:0] txd,
    input  logic       rx_act,
    input  logic       full_duplex,
    output logic       nib_tick,
    output logic       tx_nrzi,
    output logic       col
);
    logic load;
    logic ser_bit;
    cg_t  cg_next;

    assign nib_tick = load;

    pcs_tx_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tx_en   (tx_en),
        .txd     (txd),
        .cg_next (cg_next)
    );

    pcs_tx_serializer #(.W(CG_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .cg_in   (cg_next),
        .load    (load),
        .ser_bit (ser_bit)
    );

    pcs_tx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .ser_bit (ser_bit),
        .line    (tx_nrzi)
    );

    pcs_tx_col u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_duplex (full_duplex),
        .tx_en       (tx_en),
        .rx_act      (rx_act),
        .col         (col)
    );
endmodule

// File: tb/tb_pcs_tx_encoder.sv
module tb_pcs_tx_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       rx_act = 1'b0;
    logic       full_duplex = 1'b0;
    logic       nib_tick;
    logic       tx_nrzi;
    logic       col;

    int checks = 0;
    int failures = 0;

    localparam logic [4:0] E_I = 5'b11111;
    localparam logic [4:0] E_J = 5'b11000;
    localparam logic [4:0] E_K = 5'b10001;
    localparam logic [4:0] E_T = 5'b01101;
    localparam logic [4:0] E_R = 5'b00111;

    pcs_tx_encoder dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en), .txd(txd),
        .rx_act(rx_act), .full_duplex(full_duplex), .nib_tick(nib_tick),
        .tx_nrzi(tx_nrzi), .col(col)
    );

    always #5 clk = ~clk;

    // Expected code-group table, written from R1.
    function automatic logic [4:0] exp_cg(input logic [3:0] n);
        logic [4:0] t [16];
        t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    // Irregular bit-enable source.
    logic [2:0] be_ctr;
    always @(posedge clk) begin
        if (!rst_n) begin
            be_ctr <= 3'd0;
            bit_en <= 1'b0;
        end else begin
            be_ctr <= be_ctr + 3'd1;
            bit_en <= !(be_ctr == 3'd2 || be_ctr == 3'd5 || be_ctr == 3'd6);
        end
    end

    logic en_d;
    always @(posedge clk) en_d <= bit_en && rst_n;

    // Scoreboard queues.
    logic [4:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string req, input logic [4:0] act,
                         input logic [4:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Monitor: NRZI-decode the line and compare each completed group.
    logic       last_line = 1'b0;
    logic [4:0] shreg = '0;
    int         nbits = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (en_d) begin
                shreg = {shreg[3:0], tx_nrzi ^ last_line};
                last_line = tx_nrzi;
                nbits++;
                if (nbits == 5) begin
                    nbits = 0;
                    if (exp_q.size() > 0) begin
                        logic [4:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(shreg == e, t, shreg, e);
                    end
                end
            end else begin
                check(tx_nrzi == last_line, "R12", {4'b0, tx_nrzi}, {4'b0, last_line});
            end
        end
    end

    // Driver: present one slot's inputs at the sample point and push its expectation.
    task automatic slot(input logic en, input logic [3:0] d, input logic [4:0] e,
                        input string t);
        do @(negedge clk); while (!nib_tick);
        tx_en = en;
        txd   = d;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) slot(1'b0, 4'h0, E_I, "R5");
    endtask

    // Frame of n nibbles: preamble of 5s ending in D, then walking data.
    task automatic frame(input int n);
        for (int i = 0; i < n; i++) begin
            logic [3:0] d;
            d = (i < 15) ? 4'h5 : (i == 15) ? 4'hD : 4'((i * 7) & 15);
            if (i == 0)      slot(1'b1, d, E_J, "R2");
            else if (i == 1) slot(1'b1, d, E_K, "R2");
            else             slot(1'b1, d, exp_cg(d), (i < 16) ? "R3" : "R1");
        end
        slot(1'b0, 4'h0, E_T, "R4");
        slot(1'b0, 4'h0, E_R, "R4");
    endtask

    // Watchdog.
    bit done = 0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(tx_nrzi == 1'b0, "R11", {4'b0, tx_nrzi}, 5'd0);
        check(col == 1'b0, "R11", {4'b0, col}, 5'd0);
        exp_q.push_back(E_I);
        tag_q.push_back("R11");
        rst_n = 1'b1;

        idle_slots(3);
        frame(34);
        idle_slots(2);

        // R6: single-nibble frame
        slot(1'b1, 4'h5, E_J, "R6");
        slot(1'b0, 4'h0, E_K, "R6");
        slot(1'b0, 4'h0, E_T, "R6");
        slot(1'b0, 4'h0, E_R, "R6");
        idle_slots(2);

        // R7: enable high in the /R/ slot is ignored; J follows
        slot(1'b1, 4'h5, E_J, "R2");
        slot(1'b1, 4'h5, E_K, "R2");
        slot(1'b1, 4'h9, exp_cg(4'h9), "R3");
        slot(1'b0, 4'h0, E_T, "R4");
        slot(1'b1, 4'h5, E_R, "R7");
        slot(1'b1, 4'h5, E_J, "R7");
        slot(1'b1, 4'h5, E_K, "R7");

        // R9: half duplex collisions during transmit
        slot(1'b1, 4'h3, exp_cg(4'h3), "R1");
        full_duplex = 1'b0;
        rx_act = 1'b1;
        @(negedge clk);
        check(col == 1'b1, "R9", {4'b0, col}, 5'd1);
        rx_act = 1'b0;
        @(negedge clk);
        check(col == 1'b0, "R9", {4'b0, col}, 5'd0);
        // R10: full duplex holds col low
        slot(1'b1, 4'hA, exp_cg(4'hA), "R1");
        full_duplex = 1'b1;
        rx_act = 1'b1;
        @(negedge clk);
        check(col == 1'b0, "R10", {4'b0, col}, 5'd0);
        @(negedge clk);
        check(col == 1'b0, "R10", {4'b0, col}, 5'd0);
        slot(1'b0, 4'h0, E_T, "R4");
        full_duplex = 1'b0;
        rx_act = 1'b1;
        @(negedge clk);
        check(col == 1'b0, "R9", {4'b0, col}, 5'd0);
        rx_act = 1'b0;
        slot(1'b0, 4'h0, E_R, "R4");
        idle_slots(3);

        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R5", 5'(exp_q.size()), 5'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule